// File: doc/BRIEF.md
# Regulator Fault Protection Supervisor

This block sits beside the phase sequencer of a multiphase voltage regulator controller. It turns the sampled comparator flags into the controller's protective reaction. Those flags are two over-current levels, one over-voltage flag and one under-voltage flag. The threshold comparators themselves live elsewhere. Each flag arrives here as a synchronous single-bit level.

A central state machine has five states: `ST_OFF`, `ST_RUN`, `ST_OV_RAMP`, `ST_OV_HOLD` and `ST_OC_LATCH`. The transitions are:

- `ST_OFF` to `ST_RUN` when enable is high.
- `ST_RUN` to `ST_OV_RAMP` on an over-voltage trip.
- `ST_OV_RAMP` to `ST_OV_HOLD` once the ramped reference code reaches zero.
- Any of the three running states to `ST_OC_LATCH` on a severe over-current, or when the moderate over-current timer expires.
- Any state to `ST_OFF` when enable is low.

A moderate over-current starts a timer sized from the clock frequency. The timer latches off after 50 µs unless the flag clears first. A severe over-current latches off on the next clock edge.

An over-voltage trip first gates the PWMs low for as long as the flag stays high. It also captures the present reference code and walks it down to zero, one code per step interval. When the code reaches zero, the PWMs stay low and the drivers stay enabled. Both latched conditions are left only by taking enable low. The ready output follows the under-voltage flag, but only while the regulator runs without fault.

Top module: `reg_fault_supervisor`

## Requirements
- R1: With `oc_lo_i` high for `OC_LIMIT` (= CLK_FREQ_HZ/1e6 × OC_DELAY_US) consecutive clock edges in a running state, the block enters `ST_OC_LATCH` on the last of those edges. Any edge with `oc_lo_i` low clears the count to zero.
- R2: `oc_hi_i` sampled high in a running state moves the block to `ST_OC_LATCH` on that same edge.
- R3: In `ST_OC_LATCH` the outputs are `drv_en_o`=0, `pwm_force_low_o`=1 and `shutdown_o`=1. The latch holds regardless of the fault flags for as long as `en_i` stays high.
- R4: In `ST_RUN` and `ST_OV_RAMP`, `pwm_force_low_o` equals `ov_i` combinationally.
- R5: `ov_i` sampled high in `ST_RUN` captures `dac_code_i` into the override code and enters `ST_OV_RAMP`, where `shutdown_o`=1. The code then drops by one every `RAMP_STEP_CYC` edges and ignores later `dac_code_i` values. In all other states except `ST_OV_HOLD`, `dac_out_o` equals `dac_code_i`.
- R6: When the override code is zero in `ST_OV_RAMP`, the next edge enters `ST_OV_HOLD`. In `ST_OV_HOLD` the outputs are `pwm_force_low_o`=1, `drv_en_o`=1, `dac_out_o`=0 and `shutdown_o`=1, and the state is held while `en_i` is high.
- R7: `ready_o` is 1 only in `ST_RUN` with `uv_i` low. It drops combinationally when `uv_i` rises.
- R8: `en_i` sampled low moves every state to `ST_OFF`. `ST_OFF` drives `drv_en_o`=0, `pwm_force_low_o`=1, `shutdown_o`=0 and `ready_o`=0. `en_i` sampled high in `ST_OFF` enters `ST_RUN`.
- R9: Over-current takes priority over over-voltage. It applies when both flags arrive on the same edge, and it also applies from `ST_OV_RAMP` and `ST_OV_HOLD`.
- R10: Asynchronous active-low `rst_n` puts the block in `ST_OFF` with the timer and override code at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Regulator enable; low clears every latch |
| oc_lo_i | input | 1 | Moderate over-current flag (timed latch-off) |
| oc_hi_i | input | 1 | Severe over-current flag (instant latch-off) |
| ov_i | input | 1 | Over-voltage flag |
| uv_i | input | 1 | Under-voltage flag |
| dac_code_i | input | DAC_W | Present reference code from the sequencer |
| pwm_force_low_o | output | 1 | Force all PWM outputs low |
| shutdown_o | output | 1 | A protective shutdown is active |
| drv_en_o | output | 1 | Power stage driver enable |
| dac_out_o | output | DAC_W | Reference code to apply (override during over-voltage) |
| ready_o | output | 1 | Output voltage in regulation |

## Verification
Some properties are checked on every cycle: the timer stays below its limit and restarts, an instant latch follows a severe over-current, the latch holds until enable drops, PWMs are gated during over-voltage, the override code never rises within an over-voltage episode, the outputs in the hold state, ready is consistent with the fault outputs, and over-current wins over over-voltage. Only the bench scenarios can show the exact expiry edge of the 50 µs window after an interrupted fault. They also show the per-step timing of the ramp from a captured code, that a changing input code is ignored during the ramp, and the complete sequence from latch through enable cycling back to run.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_RUN      = 3'd1,
        ST_OV_RAMP  = 3'd2,
        ST_OV_HOLD  = 3'd3,
        ST_OC_LATCH = 3'd4
    } rfs_state_e;

    function automatic logic is_running(input rfs_state_e s);
        return (s == ST_RUN) || (s == ST_OV_RAMP) || (s == ST_OV_HOLD);
    endfunction

endpackage

// File: rtl/rfs_oc_timer.sv
// Consecutive-cycle qualifier for the moderate over-current flag.
module rfs_oc_timer #(
    parameter int LIMIT = 2500,
    parameter int CNT_W = $clog2(LIMIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             flag,
    output logic             expire,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = arm && flag && (cnt_q == LAST);
    assign count  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm && flag) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/rfs_dac_ramp.sv
// Captures the reference code at an over-voltage trip and walks it to zero.
module rfs_dac_ramp #(
    parameter int DAC_W         = 8,
    parameter int RAMP_STEP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DAC_W-1:0] code_in,
    output logic [DAC_W-1:0] code_out,
    output logic             at_zero
);

    localparam int STEP_W = (RAMP_STEP_CYC > 1) ? $clog2(RAMP_STEP_CYC) : 1;
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(RAMP_STEP_CYC - 1);

    logic [DAC_W-1:0]  code_q;
    logic [STEP_W-1:0] step_q;

    assign code_out = code_q;
    assign at_zero  = (code_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            step_q <= '0;
        end else if (load) begin
            code_q <= code_in;
            step_q <= '0;
        end else if (run && !at_zero) begin
            if (step_q == STEP_LAST) begin
                step_q <= '0;
                code_q <= code_q - 1'b1;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor
    import rfs_pkg::*;
#(
    parameter int CLK_FREQ_HZ   = 50_000_000,
    parameter int OC_DELAY_US   = 50,
    parameter int DAC_W         = 8,
    parameter int RAMP_STEP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             oc_lo_i,
    input  logic             oc_hi_i,
    input  logic             ov_i,
    input  logic             uv_i,
    input  logic [DAC_W-1:0] dac_code_i,
    output logic             pwm_force_low_o,
    output logic             shutdown_o,
    output logic             drv_en_o,
    output logic [DAC_W-1:0] dac_out_o,
    output logic             ready_o
);

    localparam int OC_LIMIT = (CLK_FREQ_HZ / 1_000_000) * OC_DELAY_US;
    localparam int OC_CNT_W = $clog2(OC_LIMIT);

    rfs_state_e state_q, state_d;

    logic             oc_arm;
    logic             oc_expire;
    logic [OC_CNT_W-1:0] oc_count;
    logic             ramp_load;
    logic             ramp_run;
    logic             ramp_zero;
    logic [DAC_W-1:0] ramp_code;

    assign oc_arm    = is_running(state_q) && en_i;
    assign ramp_load = (state_q == ST_RUN) && (state_d == ST_OV_RAMP);
    assign ramp_run  = (state_q == ST_OV_RAMP);

    rfs_oc_timer #(
        .LIMIT (OC_LIMIT),
        .CNT_W (OC_CNT_W)
    ) u_oc_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (oc_arm),
        .flag   (oc_lo_i),
        .expire (oc_expire),
        .count  (oc_count)
    );

    rfs_dac_ramp #(
        .DAC_W         (DAC_W),
        .RAMP_STEP_CYC (RAMP_STEP_CYC)
    ) u_dac_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ramp_load),
        .run      (ramp_run),
        .code_in  (dac_code_i),
        .code_out (ramp_code),
        .at_zero  (ramp_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic; over-current outranks over-voltage
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en_i)                       state_d = ST_OFF;
                else if (oc_hi_i || oc_expire)   state_d = ST_OC_LATCH;
                else if (ov_i)                   state_d = ST_OV_RAMP;
            end
            ST_OV_RAMP: begin
                if (!en_i)                       state_d = ST_OFF;
                else if (oc_hi_i || oc_expire)   state_d = ST_OC_LATCH;
                else if (ramp_zero)              state_d = ST_OV_HOLD;
            end
            ST_OV_HOLD: begin
                if (!en_i)                       state_d = ST_OFF;
                else if (oc_hi_i || oc_expire)   state_d = ST_OC_LATCH;
            end
            ST_OC_LATCH: begin
                if (!en_i)                       state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        pwm_force_low_o = 1'b1;
        shutdown_o      = 1'b0;
        drv_en_o        = 1'b0;
        dac_out_o       = dac_code_i;
        ready_o         = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                pwm_force_low_o = 1'b1;
            end
            ST_RUN: begin
                pwm_force_low_o = ov_i;
                drv_en_o        = 1'b1;
                ready_o         = !uv_i;
            end
            ST_OV_RAMP: begin
                pwm_force_low_o = ov_i;
                drv_en_o        = 1'b1;
                shutdown_o      = 1'b1;
                dac_out_o       = ramp_code;
            end
            ST_OV_HOLD: begin
                pwm_force_low_o = 1'b1;
                drv_en_o        = 1'b1;
                shutdown_o      = 1'b1;
                dac_out_o       = ramp_code;
            end
            ST_OC_LATCH: begin
                pwm_force_low_o = 1'b1;
                shutdown_o      = 1'b1;
            end
            default: begin
                pwm_force_low_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rfs_checker.sv
module rfs_checker
    import rfs_pkg::*;
#(
    parameter int LIMIT = 2500,
    parameter int CNT_W = 12,
    parameter int DAC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             oc_lo_i,
    input logic             oc_hi_i,
    input logic             ov_i,
    input logic             uv_i,
    input logic             pwm_force_low_o,
    input logic             shutdown_o,
    input logic             drv_en_o,
    input logic [DAC_W-1:0] dac_out_o,
    input logic             ready_o,
    input rfs_state_e       state_q,
    input logic [CNT_W-1:0] oc_count
);

    logic in_ov;
    assign in_ov = (state_q == ST_OV_RAMP) || (state_q == ST_OV_HOLD);

    assert_oc_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        32'(oc_count) < LIMIT);

    assert_oc_count_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !oc_lo_i |=> (oc_count == '0));

    assert_instant_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && oc_hi_i && drv_en_o) |=> (!drv_en_o && shutdown_o));

    assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_o && !drv_en_o && en_i) |=> (shutdown_o && !drv_en_o && pwm_force_low_o));

    assert_ov_gates_pwm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en_o && ov_i) |-> pwm_force_low_o);

    assert_ramp_never_rises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ov && $past(in_ov)) |-> (dac_out_o <= $past(dac_out_o)));

    assert_hold_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OV_HOLD) |-> (pwm_force_low_o && drv_en_o && dac_out_o == '0));

    assert_ready_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!uv_i && drv_en_o && !shutdown_o));

    assert_disable_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!drv_en_o && !shutdown_o && !ready_o));

    assert_oc_over_ov_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && drv_en_o && oc_hi_i && ov_i) |=> !drv_en_o);

endmodule

bind reg_fault_supervisor rfs_checker #(
    .LIMIT (OC_LIMIT),
    .CNT_W (OC_CNT_W),
    .DAC_W (DAC_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .en_i            (en_i),
    .oc_lo_i         (oc_lo_i),
    .oc_hi_i         (oc_hi_i),
    .ov_i            (ov_i),
    .uv_i            (uv_i),
    .pwm_force_low_o (pwm_force_low_o),
    .shutdown_o      (shutdown_o),
    .drv_en_o        (drv_en_o),
    .dac_out_o       (dac_out_o),
    .ready_o         (ready_o),
    .state_q         (state_q),
    .oc_count        (oc_count)
);

// File: tb/sim_reg_fault_supervisor.sv
`timescale 1ns/1ps
module sim_reg_fault_supervisor;

    localparam int CLK_FREQ_HZ = 50_000_000;
    localparam int OC_DELAY_US = 50;
    localparam int DAC_W       = 8;
    localparam int STEP        = 4;
    localparam int LIMIT       = (CLK_FREQ_HZ / 1_000_000) * OC_DELAY_US;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_i = 1'b0;
    logic             oc_lo_i = 1'b0;
    logic             oc_hi_i = 1'b0;
    logic             ov_i = 1'b0;
    logic             uv_i = 1'b0;
    logic [DAC_W-1:0] dac_code_i = 8'h30;
    logic             pwm_force_low_o, shutdown_o, drv_en_o, ready_o;
    logic [DAC_W-1:0] dac_out_o;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R10";
    bit    mon_on = 1'b0;
    bit    done = 1'b0;

    // model state: 0 off, 1 run, 2 ov ramp, 3 ov hold, 4 oc latch
    int m_state = 0;
    int m_cnt   = 0;
    int m_code  = 0;
    int m_step  = 0;

    always #10 clk = ~clk;

    reg_fault_supervisor #(
        .CLK_FREQ_HZ   (CLK_FREQ_HZ),
        .OC_DELAY_US   (OC_DELAY_US),
        .DAC_W         (DAC_W),
        .RAMP_STEP_CYC (STEP)
    ) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .en_i            (en_i),
        .oc_lo_i         (oc_lo_i),
        .oc_hi_i         (oc_hi_i),
        .ov_i            (ov_i),
        .uv_i            (uv_i),
        .dac_code_i      (dac_code_i),
        .pwm_force_low_o (pwm_force_low_o),
        .shutdown_o      (shutdown_o),
        .drv_en_o        (drv_en_o),
        .dac_out_o       (dac_out_o),
        .ready_o         (ready_o)
    );

    // Behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        int  nxt;
        bit  running, arm, expire, load;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_code = 0; m_step = 0;
        end else begin
            running = (m_state >= 1 && m_state <= 3);
            arm     = running && en_i;
            expire  = arm && oc_lo_i && (m_cnt == LIMIT - 1);
            nxt     = m_state;
            load    = 1'b0;
            if (m_state == 0) begin
                if (en_i) nxt = 1;
            end else if (m_state == 4) begin
                if (!en_i) nxt = 0;
            end else begin
                if (!en_i) nxt = 0;
                else if (oc_hi_i || expire) nxt = 4;
                else if (m_state == 1 && ov_i) begin nxt = 2; load = 1'b1; end
                else if (m_state == 2 && m_code == 0) nxt = 3;
            end
            if (arm && oc_lo_i) m_cnt = expire ? 0 : m_cnt + 1;
            else m_cnt = 0;
            if (load) begin
                m_code = int'(dac_code_i); m_step = 0;
            end else if (m_state == 2 && m_code != 0) begin
                if (m_step == STEP - 1) begin m_step = 0; m_code = m_code - 1; end
                else m_step = m_step + 1;
            end
            m_state = nxt;
        end
        mon_on = 1'b1;
    end

    // Compare every output with the model on each falling edge
    always @(negedge clk) begin
        bit e_force, e_sd, e_drv, e_rdy;
        int e_dac;
        if (mon_on && !done) begin
            e_force = (m_state == 1 || m_state == 2) ? ov_i : 1'b1;
            e_drv   = (m_state >= 1 && m_state <= 3);
            e_sd    = (m_state >= 2);
            e_rdy   = (m_state == 1) && !uv_i;
            e_dac   = (m_state == 2 || m_state == 3) ? m_code : int'(dac_code_i);
            checks++;
            if (pwm_force_low_o !== e_force || shutdown_o !== e_sd || drv_en_o !== e_drv ||
                ready_o !== e_rdy || int'(dac_out_o) != e_dac) begin
                errors++;
                $display("FAIL %s model: force/sd/drv/rdy/dac = %b%b%b%b/%0d expected %b%b%b%b/%0d",
                         cur_req, pwm_force_low_o, shutdown_o, drv_en_o, ready_o, dac_out_o,
                         e_force, e_sd, e_drv, e_rdy, e_dac);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycle_enable();
        en_i = 1'b0; cyc(1);
        en_i = 1'b1; cyc(1);
    endtask

    initial begin
        cyc(3);
        // R10: reset state
        cur_req = "R10";
        chk(drv_en_o == 1'b0, "R10", "drv_en in reset", int'(drv_en_o), 0);
        chk(shutdown_o == 1'b0, "R10", "shutdown in reset", int'(shutdown_o), 0);
        chk(pwm_force_low_o == 1'b1, "R10", "force low in reset", int'(pwm_force_low_o), 1);
        rst_n = 1'b1; cyc(2);
        chk(drv_en_o == 1'b0, "R8", "off while enable low", int'(drv_en_o), 0);

        // R8: enable starts the regulator
        cur_req = "R8";
        en_i = 1'b1; cyc(1);
        chk(drv_en_o == 1'b1 && pwm_force_low_o == 1'b0, "R8", "run after enable",
            int'({drv_en_o, pwm_force_low_o}), 2);

        // R7: ready follows under-voltage
        cur_req = "R7";
        chk(ready_o == 1'b1, "R7", "ready in run", int'(ready_o), 1);
        uv_i = 1'b1; #1;
        chk(ready_o == 1'b0, "R7", "ready with uv", int'(ready_o), 0);
        cyc(3); uv_i = 1'b0; cyc(1);

        // R1: interrupted moderate over-current restarts the window
        cur_req = "R1";
        oc_lo_i = 1'b1; cyc(100);
        oc_lo_i = 1'b0; cyc(1);
        oc_lo_i = 1'b1; cyc(LIMIT - 1);
        chk(drv_en_o == 1'b1, "R1", "no latch one edge short", int'(drv_en_o), 1);
        oc_lo_i = 1'b0; cyc(2);
        oc_lo_i = 1'b1; cyc(LIMIT);
        chk(drv_en_o == 1'b0 && shutdown_o == 1'b1, "R1", "latched at expiry",
            int'({drv_en_o, shutdown_o}), 1);

        // R3: latch persists with flags cleared, enable cycle clears it
        cur_req = "R3";
        oc_lo_i = 1'b0; cyc(20);
        chk(shutdown_o == 1'b1 && pwm_force_low_o == 1'b1, "R3", "latch holds",
            int'({shutdown_o, pwm_force_low_o}), 3);
        en_i = 1'b0; cyc(1);
        chk(shutdown_o == 1'b0 && drv_en_o == 1'b0, "R8", "enable low clears latch",
            int'({shutdown_o, drv_en_o}), 0);
        en_i = 1'b1; cyc(1);
        chk(drv_en_o == 1'b1, "R3", "run after recovery", int'(drv_en_o), 1);

        // R2: severe over-current latches on the next edge
        cur_req = "R2";
        oc_hi_i = 1'b1; cyc(1);
        chk(drv_en_o == 1'b0 && shutdown_o == 1'b1, "R2", "instant latch",
            int'({drv_en_o, shutdown_o}), 1);
        oc_hi_i = 1'b0; cycle_enable();

        // R4 / R5 / R6: over-voltage gating and ramp
        cur_req = "R4";
        dac_code_i = 8'd20;
        ov_i = 1'b1; #1;
        chk(pwm_force_low_o == 1'b1, "R4", "force follows ov in run", int'(pwm_force_low_o), 1);
        cyc(1);
        cur_req = "R5";
        chk(shutdown_o == 1'b1 && int'(dac_out_o) == 20 && drv_en_o == 1'b1, "R5",
            "captured code", int'(dac_out_o), 20);
        ov_i = 1'b0; #1;
        chk(pwm_force_low_o == 1'b0, "R4", "force releases when ov clears", int'(pwm_force_low_o), 0);
        dac_code_i = 8'd99;
        cyc(STEP);
        chk(int'(dac_out_o) == 19, "R5", "first decrement", int'(dac_out_o), 19);
        cyc(STEP * 19);
        chk(int'(dac_out_o) == 0, "R5", "ramp reaches zero", int'(dac_out_o), 0);
        cur_req = "R6";
        cyc(1);
        chk(pwm_force_low_o == 1'b1 && drv_en_o == 1'b1 && int'(dac_out_o) == 0, "R6",
            "hold outputs", int'({pwm_force_low_o, drv_en_o}), 3);
        cyc(10);
        chk(shutdown_o == 1'b1 && drv_en_o == 1'b1, "R6", "hold persists",
            int'({shutdown_o, drv_en_o}), 3);
        cycle_enable();
        chk(int'(dac_out_o) == 99 && shutdown_o == 1'b0, "R5", "pass-through after recovery",
            int'(dac_out_o), 99);

        // R9: over-current wins over over-voltage
        cur_req = "R9";
        dac_code_i = 8'd50;
        ov_i = 1'b1; cyc(1); ov_i = 1'b0;
        oc_hi_i = 1'b1; cyc(1); oc_hi_i = 1'b0;
        chk(drv_en_o == 1'b0 && shutdown_o == 1'b1, "R9", "oc latches from ramp",
            int'({drv_en_o, shutdown_o}), 1);
        cycle_enable();
        ov_i = 1'b1; oc_hi_i = 1'b1; cyc(1);
        ov_i = 1'b0; oc_hi_i = 1'b0;
        chk(drv_en_o == 1'b0, "R9", "simultaneous oc and ov", int'(drv_en_o), 0);
        cyc(5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        done = 1'b1;
        errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule